// File: doc/BRIEF.md
# Xoroshiro-Style Random Source with Uniform, Fraction and Gaussian Results

This block is a pseudorandom number source built around a 128-bit state held as two 64-bit words. Each accepted request reads a 64-bit output word from the current state, advances the state once, and one cycle later presents a formatted result with a valid flag. The caller picks the result format for each request with a two-bit mode field. The formats are a uniform 32-bit integer, a uniform 64-bit integer, a signed fixed-point fraction centred on zero, and a pair of approximately normal samples.

Each normal sample is a sum of twelve 4-bit uniform fields taken from a 64-bit word. The sum is re-centred to zero mean and clipped to a symmetric limit, so the sample is a quantized Irwin-Hall value of degree 12 in steps of 1/16. The two samples come from two different 64-bit words of the same state. The sum word s0+s1 supplies the low sample and the difference word s0^s1 supplies the high sample. The seed port loads the whole state in one cycle. An all-zero seed would lock the generator at zero, so the block loads a fixed nonzero constant pair in its place.

Top module: `xrs_noise_gen`

## Requirements
- R1: During and directly after synchronous active-low reset, `res_valid` is 0 and `res_data` is 0. The state holds the constant pair s0=64'h9E3779B97F4A7C15, s1=64'hBF58476D1CE4E5B9, so the first request after reset in 64-bit mode returns the sum of these two words.
- R2: A cycle with `seed_load`=1 sets s0=`seed_lo` and s1=`seed_hi`. The next request then works from this state.
- R3: If a seed load has both words zero, the state takes the reset constant pair of R1 instead.
- R4: A request produces word=s0+s1 (modulo 2^64) from the current state. With t=s0^s1, the state then becomes s0'=rotl(s0,24)^t^(t<<16) and s1'=rotl(t,37).
- R5: `res_valid` is 1 in exactly the cycle after an accepted request and 0 otherwise. While it is 0, `res_data` keeps its last value.
- R6: The state advances only on an accepted request. Idle cycles leave the output sequence unchanged.
- R7: Mode 0 (uniform 32-bit) returns word[63:32] in `res_data[31:0]`, with `res_data[63:32]`=0.
- R8: Mode 1 (uniform 64-bit) returns the full word.
- R9: Mode 2 (fraction) returns the 16-bit value {word[63], word[63:49]}, sign-extended to 64 bits. It is a Q1.15 value in [-0.5, 0.5), so the raw value lies in [-16384, 16383].
- R10: Mode 3 (Gaussian) works on the twelve nibbles in bits 47:0 of a source word. For each sample it sums those nibbles, subtracts 90, and clips the result to ±93. The result is a 16-bit two's-complement value in units of 1/16. The low sample uses the sum word and goes to `res_data[15:0]`. The high sample uses s0^s1 and goes to `res_data[31:16]`. `res_data[63:32]`=0.
- R11: Every Gaussian sample lies in [-93, +93], which is ±5.8125.
- R12: If `seed_load` and `req` are both high in the same cycle, the load wins. The request is dropped and gives no valid result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seed_load | input | 1 | Load the state from the seed words this cycle |
| seed_lo | input | 64 | Seed for state word s0 |
| seed_hi | input | 64 | Seed for state word s1 |
| req | input | 1 | Request one result |
| mode | input | 2 | Result format: 0 u32, 1 u64, 2 fraction, 3 Gaussian pair |
| res_valid | output | 1 | Result present, one cycle after the request |
| res_data | output | 64 | Formatted result |

## Verification
The generator is run from a set of seeds that includes the minimal seed 1, dense all-ones words and mixed patterns. Each seed is checked in every mode against a bench model of the update rule, and runs with different idle gaps show that only requests move the state. Chosen seeds make the output word all zeros or all ones, which drives the Gaussian sums to their extremes of -90 and +90 and the fraction to both ends of its range. A zero seed and a seed that arrives in the same cycle as a request test the substitution path and the load priority.

// File: rtl/xrs_pkg.sv
// Shared definitions for the random source: word width, request modes and
// the nonzero constant state used at reset and in place of a zero seed.
package xrs_pkg;
    localparam int WORD_W = 64;

    typedef enum logic [1:0] {
        MODE_U32   = 2'd0,
        MODE_U64   = 2'd1,
        MODE_FRAC  = 2'd2,
        MODE_GAUSS = 2'd3
    } xrs_mode_e;

    localparam logic [WORD_W-1:0] S0_INIT = 64'h9E37_79B9_7F4A_7C15;
    localparam logic [WORD_W-1:0] S1_INIT = 64'hBF58_476D_1CE4_E5B9;
endpackage

// File: rtl/xrs_state.sv
// State core: two state words with the xoroshiro-style update.
// It presents the output word (s0+s1) and the mixing word (s0^s1) from the
// current state. A load has priority over a step. An all-zero seed is
// replaced by the constant pair.
// Assumes: load and step are qualified by the caller.
module xrs_state #(
    parameter int W     = 64,
    parameter int ROT_A = 24,
    parameter int SHL_B = 16,
    parameter int ROT_C = 37,
    parameter logic [W-1:0] INIT0 = '1,
    parameter logic [W-1:0] INIT1 = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] seed0,
    input  logic [W-1:0] seed1,
    input  logic         step,
    output logic [W-1:0] word,
    output logic [W-1:0] mix
);
    logic [W-1:0] s0, s1;
    logic [W-1:0] nx0, nx1;
    logic         seed_zero;

    // Next state from the current state words.
    always_comb begin
        mix       = s0 ^ s1;
        word      = s0 + s1;
        nx0       = ((s0 << ROT_A) | (s0 >> (W - ROT_A))) ^ mix ^ (mix << SHL_B);
        nx1       = (mix << ROT_C) | (mix >> (W - ROT_C));
        seed_zero = (seed0 == '0) && (seed1 == '0);
    end

    // State register: reset, load with zero substitution, or one step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s0 <= INIT0;
            s1 <= INIT1;
        end else if (load) begin
            s0 <= seed_zero ? INIT0 : seed0;
            s1 <= seed_zero ? INIT1 : seed1;
        end else if (step) begin
            s0 <= nx0;
            s1 <= nx1;
        end
    end

    AST_STATE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (s0 | s1) != '0); // R3
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> ($stable(s0) && $stable(s1))); // R6
    AST_ZERO_SEED_SUBST: assert property (@(posedge clk) disable iff (!rst_n)
        (load && seed0 == '0 && seed1 == '0) |=> (s0 == INIT0 && s1 == INIT1)); // R3
    AST_SEED_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (load && (seed0 != '0 || seed1 != '0)) |=> (s0 == $past(seed0) && s1 == $past(seed1))); // R2
endmodule

// File: rtl/xrs_gauss_lane.sv
// One Gaussian lane: sums TERMS uniform fields of NIB bits from the low bits
// of a source word, subtracts the mean and clips to +/-CLIP.
// Assumes: TERMS*NIB <= source width and OW is wide enough for the sum.
module xrs_gauss_lane #(
    parameter int W     = 64,
    parameter int NIB   = 4,
    parameter int TERMS = 12,
    parameter int CLIP  = 93,
    parameter int OW    = 16
) (
    input  logic [W-1:0]         src,
    output logic signed [OW-1:0] sample
);
    localparam int SUMW = NIB + $clog2(TERMS) + 1;
    localparam int MEAN = TERMS * ((1 << NIB) - 1) / 2;
    localparam logic signed [OW-1:0] POS = OW'(CLIP);
    localparam logic signed [OW-1:0] NEG = -POS;

    logic [SUMW-1:0]        sum;
    logic signed [OW-1:0]   diff;

    // Add the fields, re-centre to zero and clip.
    always_comb begin
        sum = '0;
        for (int k = 0; k < TERMS; k++) begin
            sum = sum + SUMW'(src[k*NIB +: NIB]);
        end
        diff = $signed({{(OW-SUMW){1'b0}}, sum}) - $signed(OW'(MEAN));
        if (diff > POS)      sample = POS;
        else if (diff < NEG) sample = NEG;
        else                 sample = diff;
    end
endmodule

// File: rtl/xrs_format.sv
// Result formatter: turns the output word and mixing word into the requested
// format. The Gaussian pair comes from two generated lanes.
// Assumes: 2*SW <= W and FRAC_W <= W.
module xrs_format
    import xrs_pkg::*;
#(
    parameter int W      = 64,
    parameter int SW     = 16,
    parameter int FRAC_W = 16,
    parameter int NIB    = 4,
    parameter int TERMS  = 12,
    parameter int CLIP   = 93
) (
    input  logic [W-1:0] word,
    input  logic [W-1:0] mix,
    input  logic [1:0]   mode,
    output logic [W-1:0] data
);
    localparam int LANES = 2;

    logic [W-1:0]         lane_src [LANES];
    logic signed [SW-1:0] lane_out [LANES];
    logic [FRAC_W-1:0]    frac;

    assign lane_src[0] = word;
    assign lane_src[1] = mix;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        xrs_gauss_lane #(.W(W), .NIB(NIB), .TERMS(TERMS), .CLIP(CLIP), .OW(SW)) u_lane (
            .src    (lane_src[g]),
            .sample (lane_out[g])
        );
    end

    // Select and pack the result for the current mode.
    always_comb begin
        frac = {word[W-1], word[W-1 -: FRAC_W-1]};
        data = '0;
        unique case (xrs_mode_e'(mode))
            MODE_U32:   data[W/2-1:0] = word[W-1:W/2];
            MODE_U64:   data = word;
            MODE_FRAC:  data = {{(W-FRAC_W){frac[FRAC_W-1]}}, frac};
            MODE_GAUSS: begin
                data[SW-1:0]    = lane_out[0];
                data[2*SW-1:SW] = lane_out[1];
            end
            default:    data = '0;
        endcase
    end
endmodule

// File: rtl/xrs_noise_gen.sv
// Top: random source with per-request format select. A request in a cycle
// without a seed load gives a registered result one cycle later and moves
// the state one step.
// Assumes: seed_load has priority over req.
module xrs_noise_gen
    import xrs_pkg::*;
#(
    parameter int SAMPLE_W    = 16,
    parameter int FRAC_W      = 16,
    parameter int NIB_W       = 4,
    parameter int GAUSS_TERMS = 12,
    parameter int GAUSS_CLIP  = 93
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seed_load,
    input  logic [WORD_W-1:0] seed_lo,
    input  logic [WORD_W-1:0] seed_hi,
    input  logic              req,
    input  logic [1:0]        mode,
    output logic              res_valid,
    output logic [WORD_W-1:0] res_data
);
    logic              take;
    logic [WORD_W-1:0] word, mix, fmt;

    assign take = req && !seed_load;

    xrs_state #(.W(WORD_W), .INIT0(S0_INIT), .INIT1(S1_INIT)) u_state (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (seed_load),
        .seed0 (seed_lo),
        .seed1 (seed_hi),
        .step  (take),
        .word  (word),
        .mix   (mix)
    );

    xrs_format #(.W(WORD_W), .SW(SAMPLE_W), .FRAC_W(FRAC_W), .NIB(NIB_W),
                 .TERMS(GAUSS_TERMS), .CLIP(GAUSS_CLIP)) u_fmt (
        .word (word),
        .mix  (mix),
        .mode (mode),
        .data (fmt)
    );

    // Result register: capture on an accepted request, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_data  <= '0;
        end else begin
            res_valid <= take;
            if (take) res_data <= fmt;
        end
    end

    AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !seed_load) |=> res_valid); // R5
    AST_NO_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!req) |=> !res_valid); // R5
    AST_LOAD_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        seed_load |=> !res_valid); // R12
    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> $stable(res_data)); // R5
    AST_U32_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(mode) == MODE_U32) |-> res_data[WORD_W-1:WORD_W/2] == '0); // R7
    AST_GAUSS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(mode) == MODE_GAUSS) |->
        ($signed(res_data[SAMPLE_W-1:0]) <= GAUSS_CLIP &&
         $signed(res_data[SAMPLE_W-1:0]) >= -GAUSS_CLIP &&
         $signed(res_data[2*SAMPLE_W-1:SAMPLE_W]) <= GAUSS_CLIP &&
         $signed(res_data[2*SAMPLE_W-1:SAMPLE_W]) >= -GAUSS_CLIP)); // R11
    AST_FRAC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(mode) == MODE_FRAC) |->
        ($signed(res_data) <= 16383 && $signed(res_data) >= -16384)); // R9
endmodule

// File: tb/xrs_noise_gen_bench.sv
module xrs_noise_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seed_load = 1'b0;
    logic [63:0] seed_lo = '0, seed_hi = '0;
    logic        req = 1'b0;
    logic [1:0]  mode = '0;
    logic        res_valid;
    logic [63:0] res_data;

    int total = 0;
    int bad = 0;
    logic [63:0] ms0, ms1;

    always #5 clk = ~clk;

    xrs_noise_gen u_xrs_noise_gen (
        .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed_lo(seed_lo),
        .seed_hi(seed_hi), .req(req), .mode(mode),
        .res_valid(res_valid), .res_data(res_data)
    );

    typedef struct packed {
        logic [63:0] lo;
        logic [63:0] hi;
        logic [1:0]  md;
        logic [3:0]  reqs;
        logic [1:0]  gap;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{64'h0000_0000_0000_0001, 64'h0, 2'd1, 4'd6, 2'd0},
        '{64'hDEAD_BEEF_0123_4567, 64'h89AB_CDEF_FEED_FACE, 2'd0, 4'd6, 2'd1},
        '{64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 2'd2, 4'd6, 2'd0},
        '{64'h1234_5678_9ABC_DEF0, 64'h0F1E_2D3C_4B5A_6978, 2'd3, 4'd8, 2'd2},
        '{64'h8000_0000_0000_0000, 64'h0000_0000_0000_0001, 2'd2, 4'd4, 2'd3},
        '{64'hA5A5_A5A5_5A5A_5A5A, 64'h0000_FFFF_0000_FFFF, 2'd3, 4'd8, 2'd0},
        '{64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000, 2'd1, 4'd5, 2'd1},
        '{64'h7777_0000_3333_1111, 64'hCAFE_0000_0000_BABE, 2'd0, 4'd5, 2'd2}
    };

    function automatic logic [63:0] rotl(logic [63:0] v, int n);
        return (v << n) | (v >> (64 - n));
    endfunction

    function automatic logic [15:0] gsample(logic [63:0] v);
        int s = 0;
        for (int k = 0; k < 12; k++) s += int'(v[k*4 +: 4]);
        s -= 90;
        if (s > 93) s = 93;
        if (s < -93) s = -93;
        return 16'(s);
    endfunction

    function automatic logic [63:0] expect_fmt(logic [1:0] m, logic [63:0] w, logic [63:0] x);
        logic [15:0] f;
        case (m)
            2'd0: return {32'h0, w[63:32]};
            2'd1: return w;
            2'd2: begin f = {w[63], w[63:49]}; return {{48{f[15]}}, f}; end
            default: return {32'h0, gsample(x), gsample(w)};
        endcase
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_load(logic [63:0] lo, logic [63:0] hi);
        if (lo == 0 && hi == 0) begin
            ms0 = 64'h9E37_79B9_7F4A_7C15;
            ms1 = 64'hBF58_476D_1CE4_E5B9;
        end else begin
            ms0 = lo; ms1 = hi;
        end
    endtask

    task automatic model_step(output logic [63:0] w, output logic [63:0] x);
        logic [63:0] t;
        w = ms0 + ms1;
        t = ms0 ^ ms1;
        x = t;
        ms0 = rotl(ms0, 24) ^ t ^ (t << 16);
        ms1 = rotl(t, 37);
    endtask

    task automatic load_seed(logic [63:0] lo, logic [63:0] hi);
        @(negedge clk);
        seed_load = 1'b1; seed_lo = lo; seed_hi = hi;
        @(negedge clk);
        seed_load = 1'b0;
        model_load(lo, hi);
    endtask

    // One request; result sampled at the following falling edge.
    task automatic do_req(logic [1:0] m, output logic [63:0] got, output logic [63:0] exp);
        logic [63:0] w, x;
        @(negedge clk);
        req = 1'b1; mode = m;
        @(negedge clk);
        req = 1'b0;
        model_step(w, x);
        exp = expect_fmt(m, w, x);
        got = res_data;
        check("R5 valid", {63'h0, res_valid}, 64'h1);
    endtask

    function automatic string mode_tag(logic [1:0] m);
        case (m)
            2'd0: return "R7 u32";
            2'd1: return "R4 R8 u64";
            2'd2: return "R9 frac";
            default: return "R10 gauss";
        endcase
    endfunction

    initial begin
        #1_000_000;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [63:0] got, exp, held;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 valid", {63'h0, res_valid}, 64'h0);
        check("R1 data", res_data, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", {63'h0, res_valid}, 64'h0);
        model_load(64'h0, 64'h0);
        do_req(2'd1, got, exp);
        check("R1 first word", got, 64'h9E37_79B9_7F4A_7C15 + 64'hBF58_476D_1CE4_E5B9);

        // Table walk: seed, then requests with idle gaps.
        for (int v = 0; v < 8; v++) begin
            load_seed(VECS[v].lo, VECS[v].hi);
            for (int r = 0; r < int'(VECS[v].reqs); r++) begin
                do_req(VECS[v].md, got, exp);
                check(mode_tag(VECS[v].md), got, exp);
                if (VECS[v].md == 2'd3) begin
                    check("R11 low in range",
                          {63'h0, ($signed(got[15:0]) <= 93 && $signed(got[15:0]) >= -93)}, 64'h1);
                    check("R11 high in range",
                          {63'h0, ($signed(got[31:16]) <= 93 && $signed(got[31:16]) >= -93)}, 64'h1);
                end
                held = res_data;
                for (int g = 0; g < int'(VECS[v].gap); g++) begin
                    @(negedge clk);
                    check("R5 idle valid", {63'h0, res_valid}, 64'h0);
                    check("R6 idle hold", res_data, held);
                end
            end
        end

        // R2 seed sum, directed U32 value
        load_seed(64'h0000_0001_0000_0000, 64'h0000_0002_0000_0000);
        do_req(2'd0, got, exp);
        check("R2 R7 seed word u32", got, 64'h3);

        // R3 zero seed gives constant pair
        load_seed(64'h0, 64'h0);
        do_req(2'd1, got, exp);
        check("R3 zero seed", got, 64'h9E37_79B9_7F4A_7C15 + 64'hBF58_476D_1CE4_E5B9);

        // R10 extremes: all-zero word and mix
        load_seed(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000);
        do_req(2'd3, got, exp);
        check("R10 gauss min", got, {32'h0, 16'hFFA6, 16'hFFA6});

        // R10 extremes: all-ones word and mix
        load_seed(64'hFFFF_FFFF_FFFF_FFFF, 64'h0);
        do_req(2'd3, got, exp);
        check("R10 gauss max", got, {32'h0, 16'h005A, 16'h005A});

        // R9 fraction ends
        load_seed(64'h8000_0000_0000_0000, 64'h1);
        do_req(2'd2, got, exp);
        check("R9 frac low end", got, {{48{1'b1}}, 16'hC000});
        load_seed(64'h7FFF_FFFF_FFFF_FFFF, 64'h0);
        do_req(2'd2, got, exp);
        check("R9 frac high end", got, 64'h0000_0000_0000_3FFF);

        // R12 load and request together: load wins, no result
        @(negedge clk);
        seed_load = 1'b1; req = 1'b1; mode = 2'd1;
        seed_lo = 64'h0000_0000_0000_0010; seed_hi = 64'h0000_0000_0000_0020;
        @(negedge clk);
        seed_load = 1'b0; req = 1'b0;
        model_load(64'h10, 64'h20);
        check("R12 no valid", {63'h0, res_valid}, 64'h0);
        do_req(2'd1, got, exp);
        check("R12 load kept", got, 64'h30);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule